// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit sits in the memory stage of a 32-bit soft processor. It takes a register-form load or store instruction word and the two operand register values with their indices. From these it forms the memory address and decodes the access size and the byte-reverse and exclusive attributes. It also reports whether the access must skip address translation. One cycle after a request, every result appears on registered outputs together with a valid strobe.

A per-instruction wide-address bit selects between two address modes. When the bit is clear, the address is the 32-bit sum of the operands. When it is set, the two registers are joined into one physical address of up to 64 bits, with the first operand as the upper word. That address is cut down to the physical width chosen at build time, and it bypasses translation. Wide addressing is privileged: from user mode it raises a trap and the access is not issued. A separate, enable-gated check flags multi-byte accesses that are not aligned. The unit reports at most one of the two exceptions per access, and the trap wins.

Top module: `ldst_agen`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid, out_issue, out_priv_trap, out_align_fault, out_bypass, out_rev, out_excl, out_size_log2 and out_addr are all zero.
- R2: A request with req_valid=1 and instruction bit 29 clear (register form) yields out_valid=1 exactly one cycle later. A request with bit 29 set yields no out_valid.
- R3: out_size_log2 equals instruction bits [27:26], and the access is 1 << that value bytes long. out_rev equals instruction bit 9 and out_excl equals instruction bit 10.
- R4: An operand whose index is 0 reads as zero. With instruction bit 7 clear, out_addr is (ra + rb) mod 2^32, zero-extended to 64 bits. So with ra index 0 the address is rb alone.
- R5: With instruction bit 7 set, out_addr is {ra, rb} with ra in bits [63:32], and bits at or above PA_W are forced to zero. When PA_W is 32, the result is rb zero-extended. PA_W is limited to 32..64 at elaboration.
- R6: out_bypass (no-translation context) equals instruction bit 7 of the request.
- R7: A wide-address request (bit 7 set) made while user_mode=1 sets out_priv_trap and clears out_issue.
- R8: With align_chk_en=1 and a size above one byte, an address that is not a multiple of the size sets out_align_fault. Byte accesses, and any access while align_chk_en=0, never fault.
- R9: out_priv_trap and out_align_fault are never both set, and the trap takes priority. out_issue is 1 exactly when out_valid is 1 and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| instr | input | 32 | Load/store instruction word |
| ra_val | input | 32 | First operand value |
| rb_val | input | 32 | Second operand value |
| ra_idx | input | 5 | First operand register index |
| rb_idx | input | 5 | Second operand register index |
| user_mode | input | 1 | Processor is in user mode |
| align_chk_en | input | 1 | Enable the misalignment fault |
| out_valid | output | 1 | Results valid |
| out_addr | output | 64 | Effective address |
| out_size_log2 | output | 2 | Log2 of the access size in bytes |
| out_rev | output | 1 | Byte-reverse attribute |
| out_excl | output | 1 | Exclusive attribute |
| out_bypass | output | 1 | Use the no-translation context |
| out_priv_trap | output | 1 | Privilege trap |
| out_align_fault | output | 1 | Alignment fault |
| out_issue | output | 1 | Access may be sent to memory |

## Verification
The privilege trap and the alignment fault can both be triggered by the same access. This happens with a user-mode, wide-address, multi-byte request whose address is misaligned while checking is enabled. The bench builds exactly that request, with a halfword and a word size. It expects the trap alone, no fault and out_issue low. It also sends the same misaligned address from kernel mode, which must then report the fault on its own.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;
  localparam int XLEN      = 32;
  localparam int OUT_W     = 64;
  localparam int IDX_W     = 5;
  localparam int SIZE_LSB  = 26;
  localparam int TYPEB_BIT = 29;
  localparam int WIDE_BIT  = 7;
  localparam int REV_BIT   = 9;
  localparam int EXCL_BIT  = 10;

  typedef struct packed {
    logic       regform;
    logic       wide;
    logic       rev;
    logic       excl;
    logic [1:0] size_log2;
  } ls_dec_t;
endpackage

// File: rtl/agen_decode.sv
module agen_decode
  import ldst_agen_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ls_dec_t         dec
);
  logic unused_instr_bits;

  always_comb begin
    dec.regform   = ~instr[TYPEB_BIT];
    dec.size_log2 = instr[SIZE_LSB+1:SIZE_LSB];
    // the attribute bits exist only in the register form
    dec.wide      = dec.regform & instr[WIDE_BIT];
    dec.rev       = dec.regform & instr[REV_BIT];
    dec.excl      = dec.regform & instr[EXCL_BIT];
  end

  assign unused_instr_bits = ^{instr[31:30], instr[28], instr[25:11], instr[8], instr[6:0]};
endmodule

// File: rtl/agen_addr.sv
module agen_addr
  import ldst_agen_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic             wide,
  output logic [OUT_W-1:0] addr
);
  logic [XLEN-1:0]  ra_eff, rb_eff, sum32;
  logic [OUT_W-1:0] wide_addr;

  assign ra_eff = (ra_idx == '0) ? '0 : ra_val;
  assign rb_eff = (rb_idx == '0) ? '0 : rb_val;
  assign sum32  = ra_eff + rb_eff;

  generate
    if (PA_W == XLEN) begin : g_narrow
      assign wide_addr = {{(OUT_W-XLEN){1'b0}}, rb_eff};
    end else if (PA_W < OUT_W) begin : g_masked
      localparam logic [OUT_W-1:0] PA_MASK = (OUT_W'(1) << PA_W) - OUT_W'(1);
      assign wide_addr = {ra_eff, rb_eff} & PA_MASK;
    end else begin : g_full
      assign wide_addr = {ra_eff, rb_eff};
    end
  endgenerate

  assign addr = wide ? wide_addr : {{(OUT_W-XLEN){1'b0}}, sum32};
endmodule

// File: rtl/agen_check.sv
module agen_check
  import ldst_agen_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  logic [1:0] size_log2,
  input  logic       wide,
  input  logic       user_mode,
  input  logic       align_chk_en,
  output logic       priv_trap,
  output logic       align_fault
);
  logic [2:0] lo_mask;
  logic       misaligned;

  assign lo_mask     = (3'd1 << size_log2) - 3'd1;
  assign misaligned  = (addr_lo & lo_mask) != 3'd0;
  assign priv_trap   = wide & user_mode;
  assign align_fault = ~priv_trap & align_chk_en & misaligned;
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      instr,
  input  logic [31:0]      ra_val,
  input  logic [31:0]      rb_val,
  input  logic [4:0]       ra_idx,
  input  logic [4:0]       rb_idx,
  input  logic             user_mode,
  input  logic             align_chk_en,
  output logic             out_valid,
  output logic [63:0]      out_addr,
  output logic [1:0]       out_size_log2,
  output logic             out_rev,
  output logic             out_excl,
  output logic             out_bypass,
  output logic             out_priv_trap,
  output logic             out_align_fault,
  output logic             out_issue
);
  generate
    if (PA_W < XLEN || PA_W > OUT_W) begin : g_bad_width
      $error("ldst_agen: PA_W must lie in 32..64");
    end
  endgenerate

  ls_dec_t          dec;
  logic [OUT_W-1:0] addr_c;
  logic             trap_c, fault_c, take;

  agen_decode u_dec (.instr(instr), .dec(dec));

  agen_addr #(.PA_W(PA_W)) u_addr (
    .ra_val(ra_val), .rb_val(rb_val), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .wide(dec.wide), .addr(addr_c)
  );

  agen_check u_chk_logic (
    .addr_lo(addr_c[2:0]), .size_log2(dec.size_log2), .wide(dec.wide),
    .user_mode(user_mode), .align_chk_en(align_chk_en),
    .priv_trap(trap_c), .align_fault(fault_c)
  );

  assign take = req_valid & dec.regform;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_addr        <= '0;
      out_size_log2   <= '0;
      out_rev         <= 1'b0;
      out_excl        <= 1'b0;
      out_bypass      <= 1'b0;
      out_priv_trap   <= 1'b0;
      out_align_fault <= 1'b0;
      out_issue       <= 1'b0;
    end else begin
      out_valid <= take;
      out_issue <= take & ~trap_c & ~fault_c;
      if (take) begin
        out_addr        <= addr_c;
        out_size_log2   <= dec.size_log2;
        out_rev         <= dec.rev;
        out_excl        <= dec.excl;
        out_bypass      <= dec.wide;
        out_priv_trap   <= trap_c;
        out_align_fault <= fault_c;
      end
    end
  end
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
  parameter int PA_W = 40
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] instr,
  input logic        user_mode,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic        out_bypass,
  input logic        out_priv_trap,
  input logic        out_align_fault,
  input logic        out_issue
);
  localparam logic [63:0] HI_BITS = ~((64'd1 << PA_W) - 64'd1);
  logic unused_chk_bits;
  assign unused_chk_bits = ^{instr[31:30], instr[28:8], instr[6:0]};

  // R2
  req_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !instr[29]) |=> out_valid);
  // R2
  no_req_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || instr[29]) |=> !out_valid);
  // R5
  addr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && PA_W < 64) |-> ((out_addr & HI_BITS) == 64'd0));
  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !instr[29]) |=> (out_bypass == $past(instr[7])));
  // R7
  user_wide_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !instr[29] && instr[7] && user_mode) |=> (out_priv_trap && !out_issue));
  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_priv_trap && out_align_fault));
  // R9
  issue_chk: assert property (@(posedge clk) disable iff (rst)
    out_issue |-> (out_valid && !out_priv_trap && !out_align_fault));
endmodule

bind ldst_agen ldst_agen_chk #(.PA_W(PA_W)) u_agen_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
  .user_mode(user_mode), .out_valid(out_valid), .out_addr(out_addr),
  .out_bypass(out_bypass), .out_priv_trap(out_priv_trap),
  .out_align_fault(out_align_fault), .out_issue(out_issue)
);

// File: tb/test_ldst_agen.sv
module test_ldst_agen;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 40;

  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  sz;
    logic        rev, excl, byp, trap, fault, issue;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [31:0] instr = '0, ra_val = '0, rb_val = '0;
  logic [4:0] ra_idx = '0, rb_idx = '0;
  logic user_mode = 1'b0, align_chk_en = 1'b0;
  logic out_valid, out_rev, out_excl, out_bypass, out_priv_trap, out_align_fault, out_issue;
  logic [63:0] out_addr;
  logic [1:0] out_size_log2;

  int checks = 0, errors = 0, popped = 0, pushed = 0;
  exp_t sb[$];

  ldst_agen #(.PA_W(PA_W)) i_ldst_agen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
    .ra_val(ra_val), .rb_val(rb_val), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .user_mode(user_mode), .align_chk_en(align_chk_en),
    .out_valid(out_valid), .out_addr(out_addr), .out_size_log2(out_size_log2),
    .out_rev(out_rev), .out_excl(out_excl), .out_bypass(out_bypass),
    .out_priv_trap(out_priv_trap), .out_align_fault(out_align_fault),
    .out_issue(out_issue)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: computes expectations from the requirements and pushes them
  task automatic send(input logic [1:0] sz, input bit wide, input bit rv, input bit ex,
                      input bit typeb, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] ai, input logic [4:0] bi, input bit usr, input bit aln);
    exp_t e;
    logic [31:0] ae, be;
    logic [2:0] lm;
    @(negedge clk);
    instr = 32'hC000_0000;
    instr[27:26] = sz; instr[29] = typeb; instr[7] = wide; instr[9] = rv; instr[10] = ex;
    ra_val = a; rb_val = b; ra_idx = ai; rb_idx = bi;
    user_mode = usr; align_chk_en = aln; req_valid = 1'b1;
    ae = (ai == 0) ? 32'd0 : a;
    be = (bi == 0) ? 32'd0 : b;
    if (wide) e.addr = (PA_W == 32) ? {32'd0, be} : ({ae, be} & ((64'd1 << PA_W) - 64'd1));
    else      e.addr = {32'd0, ae + be};
    e.sz = sz; e.rev = rv; e.excl = ex; e.byp = wide;
    e.trap = wide && usr;
    lm = (3'd1 << sz) - 3'd1;
    e.fault = !e.trap && aln && ((e.addr[2:0] & lm) != 3'd0);
    e.issue = !e.trap && !e.fault;
    if (!typeb) begin sb.push_back(e); pushed++; end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops and compares at the falling edge after each registered result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) chk(1'b0, "R2 unexpected out_valid", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        popped++;
        chk(out_addr == e.addr, "R4/R5 addr", out_addr, e.addr);
        chk(out_size_log2 == e.sz, "R3 size", 64'(out_size_log2), 64'(e.sz));
        chk({out_rev, out_excl} == {e.rev, e.excl}, "R3 rev/excl", 64'({out_rev, out_excl}), 64'({e.rev, e.excl}));
        chk(out_bypass == e.byp, "R6 bypass", 64'(out_bypass), 64'(e.byp));
        chk(out_priv_trap == e.trap, "R7 trap", 64'(out_priv_trap), 64'(e.trap));
        chk(out_align_fault == e.fault, "R8 fault", 64'(out_align_fault), 64'(e.fault));
        chk(out_issue == e.issue, "R9 issue", 64'(out_issue), 64'(e.issue));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero under reset
    chk({out_valid, out_issue, out_priv_trap, out_align_fault, out_bypass, out_rev, out_excl} == 7'd0 &&
        out_addr == 64'd0 && out_size_log2 == 2'd0, "R1 reset", out_addr, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_addr == 64'd0, "R1 after reset", 64'(out_valid), 64'd0);

    // R4: plain sum, aligned word, checking on
    send(2'd2, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_0024, 5'd3, 5'd4, 0, 1);
    // R4: sum wraps at 32 bits (back to back)
    send(2'd2, 0, 0, 0, 0, 32'hFFFF_FFF0, 32'h0000_0020, 5'd3, 5'd4, 0, 1);
    // R4: ra index 0 reads zero
    send(2'd0, 0, 1, 0, 0, 32'hDEAD_BEEF, 32'h0000_0077, 5'd0, 5'd4, 0, 1);
    // R4: rb index 0 reads zero
    send(2'd1, 0, 0, 1, 0, 32'h0000_0100, 32'h1234_5678, 5'd5, 5'd0, 0, 0);
    // R5 R6: wide address masked to 40 bits, kernel mode
    send(2'd2, 1, 0, 0, 0, 32'hABCD_1234, 32'h5678_0000, 5'd6, 5'd7, 0, 1);
    // R5: wide with ra index 0 keeps upper word zero
    send(2'd3, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h8000_0008, 5'd0, 5'd7, 0, 0);
    // R7: wide in user mode traps
    send(2'd2, 1, 0, 0, 0, 32'h0000_00FF, 32'h0000_0040, 5'd1, 5'd2, 1, 0);
    // R9: trap and misalignment together -> trap only
    send(2'd1, 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0003, 5'd1, 5'd2, 1, 1);
    send(2'd2, 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0006, 5'd1, 5'd2, 1, 1);
    // R8: same misaligned address in kernel mode -> fault only
    send(2'd1, 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0003, 5'd1, 5'd2, 0, 1);
    // R8: misaligned halfword and word, checking on
    send(2'd1, 0, 0, 0, 0, 32'h0000_0010, 32'h0000_0001, 5'd1, 5'd2, 0, 1);
    send(2'd2, 0, 0, 0, 0, 32'h0000_0010, 32'h0000_0002, 5'd1, 5'd2, 0, 1);
    // R8: misaligned word with checking off
    send(2'd2, 0, 0, 0, 0, 32'h0000_0010, 32'h0000_0003, 5'd1, 5'd2, 0, 0);
    // R8: odd byte never faults
    send(2'd0, 0, 0, 0, 0, 32'h0000_0010, 32'h0000_0003, 5'd1, 5'd2, 0, 1);
    // R3: user mode without wide addressing is fine, all flags
    send(2'd1, 0, 1, 1, 0, 32'h0000_2000, 32'h0000_0002, 5'd8, 5'd9, 1, 1);
    idle();
    idle();

    // R2: immediate form (bit 29 set) produces no result
    send(2'd2, 0, 0, 0, 1, 32'h0000_1000, 32'h0000_0004, 5'd1, 5'd2, 0, 1);
    idle();
    chk(out_valid == 1'b0, "R2 type-B ignored", 64'(out_valid), 64'd0);
    idle();
    chk(out_valid == 1'b0, "R2 idle no valid", 64'(out_valid), 64'd0);

    repeat (3) @(negedge clk);
    chk(popped == pushed && sb.size() == 0, "R2 all results delivered", 64'(popped), 64'(pushed));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule